// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets an external host read and write an on-chip register file over a three-wire serial link: a serial clock, an active-low select and one shared data line. The data line is split at this boundary into an input, an output and an output enable. The pad ring merges them into one bidirectional pin. The block drives the line only while it returns read data.

Each select-low period carries one transaction. The host first sends a 16-bit header, most significant bit first. Bit 15 is the direction. Bits 14:13 are a length code. Bits 12:0 are the start register address. Data bytes follow the header. The address steps up by one for each byte. A length code of 11 streams bytes until select rises. The lower codes cap the transfer at one, two or three bytes. The register file sees a one-cycle write strobe with address and data, and a one-cycle read request whose data it returns combinationally.

All serial pins pass through a `SYNC_STAGES`-deep synchronizer into the system clock domain. Every response therefore follows its serial-pin event by a fixed number of system clock edges. The host's serial clock half-period must exceed `SYNC_STAGES + 3` system clock periods.

Top module: `spi3_reg_slave`

## Requirements
- R1: The output enable is high only in the data phase of a read (header bit 15 = 1). It is low during the header, during every write and while select is high.
- R2: Select going high at any point returns the block to idle within `SYNC_STAGES + 1` clock edges: the data line is released and the bit and byte counters clear. The next select-low period decodes a fresh header.
- R3: Header bit 15 selects the direction (0 write, 1 read). Bits 14:13 are the length code. Bits 12:0 are the start address. All header bits arrive most significant bit first.
- R4: The first data byte uses the header address. Each later byte uses the previous address plus one, wrapping modulo 2^13.
- R5: Length codes 00, 01 and 10 allow 1, 2 and 3 data bytes. Write bytes beyond that count produce no write strobe. On read bytes beyond it, the data line stays released.
- R6: Length code 11 transfers any number of bytes until select rises.
- R7: Bits move most significant bit first. Input is sampled on the rising serial clock edge. Output changes only after a falling serial clock edge.
- R8: Each complete, in-count write byte produces exactly one one-cycle `rf_we` pulse carrying that byte's address and data. The pulse comes on the `SYNC_STAGES + 1`-th clock edge after the byte's eighth rising serial clock edge.
- R9: A data byte cut short by select rising is discarded, with no write strobe.
- R10: A read pulses `rf_re` for one cycle at the current address. This happens `SYNC_STAGES + 1` clock edges after the last header bit, and again after each completed byte whose successor is in count. `rf_we` and `rf_re` are never high together.
- R11: The data output and its enable update on the `SYNC_STAGES + 1`-th clock edge after the falling serial clock edge that drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sdio_i | input | 1 | Data line as received from the pad |
| spi_sdio_o | output | 1 | Data line value to drive during reads |
| spi_sdio_oe | output | 1 | Pad output enable for the data line |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_re | output | 1 | One-cycle register read request |
| rf_addr | output | 13 | Register address for the strobe or request |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, valid in the cycle of `rf_re` |

## Verification
Every serial-pin change the bench makes lands on the `SYNC_STAGES + 1`-th rising clock edge after it, counting the synchronizer flops and the edge-detect register. The bench therefore files each expected write strobe, read request and data-line level under that future cycle number when it drives the edge that causes it. On every clock, half a period after the edge, it compares the outputs against whatever is filed for the current cycle. Read bits are sampled as the host would sample them, at the following rising serial edge, well after the output has settled. Register contents are compared after each transaction.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

   localparam int HDR_BITS  = 16;
   localparam int ADDR_BITS = 13;
   localparam int BYTE_BITS = 8;
   localparam int HDR_CNT_W = $clog2(HDR_BITS);

   // Length code in header bits 14:13
   typedef enum logic [1:0] {
      LEN_ONE   = 2'b00,
      LEN_TWO   = 2'b01,
      LEN_THREE = 2'b10,
      LEN_OPEN  = 2'b11
   } len_code_e;

   // Header as shifted in, first bit received lands in rd
   typedef struct packed {
      logic                 rd;
      len_code_e            len;
      logic [ADDR_BITS-1:0] addr;
   } hdr_t;

   // True when the byte following 'done' completed bytes is inside the coded count
   function automatic logic byte_in_range(len_code_e len, logic [7:0] done);
      return (len == LEN_OPEN) || (done <= 8'(len));
   endfunction

endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
   parameter int                STAGES  = 2,
   parameter int                WIDTH   = 3,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
               stg_q[0] <= din;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign dout = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
   import spi3_pkg::*;
#(
   parameter int BYTE_CNT_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_hi,
   input  logic                 rise,
   input  logic                 sdi,
   output logic                 in_data,
   output logic                 rd,
   output logic [ADDR_BITS-1:0] cur_addr,
   output logic                 cur_ok,
   output logic                 hdr_done,
   output logic                 byte_done,
   output logic                 byte_ok,
   output logic [ADDR_BITS-1:0] byte_addr,
   output logic [BYTE_BITS-1:0] byte_data
);

   logic [HDR_BITS-2:0]   rx_q;
   logic [HDR_CNT_W-1:0]  bit_q;
   logic [BYTE_CNT_W-1:0] cnt_q;
   len_code_e             len_q;
   hdr_t                  hdr_w;

   assign hdr_w  = {rx_q, sdi};
   assign cur_ok = byte_in_range(len_q, 8'(cnt_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q      <= '0;
         bit_q     <= '0;
         cnt_q     <= '0;
         len_q     <= LEN_ONE;
         in_data   <= 1'b0;
         rd        <= 1'b0;
         cur_addr  <= '0;
         hdr_done  <= 1'b0;
         byte_done <= 1'b0;
         byte_ok   <= 1'b0;
         byte_addr <= '0;
         byte_data <= '0;
      end else begin
         hdr_done  <= 1'b0;
         byte_done <= 1'b0;
         if (cs_hi) begin
            bit_q   <= '0;
            cnt_q   <= '0;
            in_data <= 1'b0;
         end else if (rise) begin
            rx_q <= {rx_q[HDR_BITS-3:0], sdi};
            if (!in_data) begin
               if (bit_q == HDR_CNT_W'(HDR_BITS-1)) begin
                  bit_q    <= '0;
                  in_data  <= 1'b1;
                  rd       <= hdr_w.rd;
                  len_q    <= hdr_w.len;
                  cur_addr <= hdr_w.addr;
                  hdr_done <= 1'b1;
               end else begin
                  bit_q <= bit_q + HDR_CNT_W'(1);
               end
            end else begin
               if (bit_q == HDR_CNT_W'(BYTE_BITS-1)) begin
                  bit_q     <= '0;
                  byte_done <= 1'b1;
                  byte_ok   <= cur_ok;
                  byte_addr <= cur_addr;
                  byte_data <= {rx_q[BYTE_BITS-2:0], sdi};
                  cur_addr  <= cur_addr + ADDR_BITS'(1);
                  if (cnt_q != '1) cnt_q <= cnt_q + BYTE_CNT_W'(1);
               end else begin
                  bit_q <= bit_q + HDR_CNT_W'(1);
               end
            end
         end
      end
   end

endmodule

// File: rtl/spi3_tx.sv
module spi3_tx
   import spi3_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_hi,
   input  logic                 fall,
   input  logic                 drive_en,
   input  logic                 load,
   input  logic [BYTE_BITS-1:0] load_data,
   output logic                 sdo,
   output logic                 oe
);

   logic [BYTE_BITS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         sdo  <= 1'b0;
         oe   <= 1'b0;
      end else begin
         if (cs_hi) begin
            oe <= 1'b0;
         end else if (fall) begin
            oe <= drive_en;
            if (drive_en) sdo <= sh_q[BYTE_BITS-1];
         end
         if (load) begin
            sh_q <= load_data;
         end else if (fall && drive_en && !cs_hi) begin
            sh_q <= {sh_q[BYTE_BITS-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/spi3_reg_slave.sv
module spi3_reg_slave
   import spi3_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_CNT_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sclk,
   input  logic                 spi_cs_n,
   input  logic                 spi_sdio_i,
   output logic                 spi_sdio_o,
   output logic                 spi_sdio_oe,
   output logic                 rf_we,
   output logic                 rf_re,
   output logic [ADDR_BITS-1:0] rf_addr,
   output logic [BYTE_BITS-1:0] rf_wdata,
   input  logic [BYTE_BITS-1:0] rf_rdata
);

   localparam int PIN_W = 3;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end
   if (BYTE_CNT_W < 2 || BYTE_CNT_W > 8) begin : g_bad_cnt
      $error("BYTE_CNT_W must lie in 2..8");
   end

   logic [PIN_W-1:0]     pins_s;
   logic                 cs_hi, sclk_s, sdi_s, sclk_prev;
   logic                 sclk_rise, sclk_fall;
   logic                 in_data, rd, cur_ok, rd_phase;
   logic                 hdr_done, byte_done, byte_ok;
   logic [ADDR_BITS-1:0] cur_addr, byte_addr;
   logic [BYTE_BITS-1:0] byte_data;

   spi3_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (PIN_W),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs_n, spi_sclk, spi_sdio_i}),
      .dout (pins_s)
   );

   assign cs_hi  = pins_s[2];
   assign sclk_s = pins_s[1];
   assign sdi_s  = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign sclk_rise = sclk_s & ~sclk_prev;
   assign sclk_fall = ~sclk_s & sclk_prev;

   spi3_frame #(
      .BYTE_CNT_W(BYTE_CNT_W)
   ) i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_hi    (cs_hi),
      .rise     (sclk_rise),
      .sdi      (sdi_s),
      .in_data  (in_data),
      .rd       (rd),
      .cur_addr (cur_addr),
      .cur_ok   (cur_ok),
      .hdr_done (hdr_done),
      .byte_done(byte_done),
      .byte_ok  (byte_ok),
      .byte_addr(byte_addr),
      .byte_data(byte_data)
   );

   assign rd_phase = in_data & rd;
   assign rf_re    = (hdr_done | byte_done) & rd_phase & cur_ok & ~cs_hi;
   assign rf_we    = byte_done & ~rd & byte_ok;
   assign rf_addr  = rf_we ? byte_addr : cur_addr;
   assign rf_wdata = byte_data;

   spi3_tx i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_hi    (cs_hi),
      .fall     (sclk_fall),
      .drive_en (rd_phase & cur_ok),
      .load     (rf_re),
      .load_data(rf_rdata),
      .sdo      (spi_sdio_o),
      .oe       (spi_sdio_oe)
   );

endmodule

// File: rtl/spi3_reg_slave_chk.sv
module spi3_reg_slave_chk
   import spi3_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_hi,
   input logic                 sclk_fall,
   input logic                 rd_phase,
   input logic                 byte_done,
   input logic [ADDR_BITS-1:0] byte_addr,
   input logic [ADDR_BITS-1:0] cur_addr,
   input logic                 rf_we,
   input logic                 rf_re,
   input logic                 spi_sdio_o,
   input logic                 spi_sdio_oe
);

   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) spi_sdio_oe |-> rd_phase); // R1
   AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) cs_hi |=> !spi_sdio_oe); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) byte_done |-> (cur_addr == byte_addr + ADDR_BITS'(1))); // R4
   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sclk_fall |=> $stable(spi_sdio_o)); // R7
   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we); // R8
   AST_WE_RE_APART: assert property (@(posedge clk) disable iff (!rst_n) !(rf_we && rf_re)); // R10

endmodule

bind spi3_reg_slave spi3_reg_slave_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_hi      (cs_hi),
   .sclk_fall  (sclk_fall),
   .rd_phase   (rd_phase),
   .byte_done  (byte_done),
   .byte_addr  (byte_addr),
   .cur_addr   (cur_addr),
   .rf_we      (rf_we),
   .rf_re      (rf_re),
   .spi_sdio_o (spi_sdio_o),
   .spi_sdio_oe(spi_sdio_oe)
);

// File: tb/test_spi3_reg_slave.sv
module test_spi3_reg_slave;

   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;
   localparam int H    = 6;
   localparam int NREG = 8192;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, sclk, cs_n, sdi;
   logic        sdo, oe, we, re;
   logic [12:0] addr;
   logic [7:0]  wdata, rdata;

   logic [7:0] rf_mem  [NREG];
   logic [7:0] exp_mem [NREG];

   int cyc = 0, checks = 0, errors = 0;
   bit done = 0;

   bit [20:0] we_at [int];
   bit        re_at [int];
   bit        oe_at [int];
   bit        o_at  [int];
   bit        exp_oe = 0, exp_o = 0;

   spi3_reg_slave #(.SYNC_STAGES(SYNC), .BYTE_CNT_W(3)) i_spi3_reg_slave (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdio_i(sdi),
      .spi_sdio_o(sdo), .spi_sdio_oe(oe), .rf_we(we), .rf_re(re),
      .rf_addr(addr), .rf_wdata(wdata), .rf_rdata(rdata)
   );

   // register file seen by the block
   always @(posedge clk) if (we) rf_mem[addr] <= wdata;
   assign rdata = rf_mem[addr];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // per-clock comparison against the scheduled reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (oe_at.exists(cyc)) begin exp_oe = oe_at[cyc]; oe_at.delete(cyc); end
         if (o_at.exists(cyc))  begin exp_o  = o_at[cyc];  o_at.delete(cyc);  end
         check(oe == exp_oe, "R1/R5/R11", "sdio_oe", int'(oe), int'(exp_oe));
         if (exp_oe) check(sdo == exp_o, "R7/R11", "sdio_o", int'(sdo), int'(exp_o));
         check(we == we_at.exists(cyc), "R8/R9", "rf_we", int'(we), we_at.exists(cyc));
         if (we_at.exists(cyc)) begin
            if (we) check({addr, wdata} == we_at[cyc], "R4/R8", "write addr/data",
                          int'({addr, wdata}), int'(we_at[cyc]));
            we_at.delete(cyc);
         end
         check(re == re_at.exists(cyc), "R10", "rf_re", int'(re), re_at.exists(cyc));
         if (re_at.exists(cyc)) re_at.delete(cyc);
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit in_count(bit [1:0] len, int j);
      return (len == 2'b11) || (j <= int'(len));
   endfunction

   // one transaction: nbytes full bytes, then tail bits of a cut-short byte
   task automatic xfer(bit rd, bit [1:0] len, bit [12:0] a, int nbytes, int tail, bit [7:0] seed);
      bit [15:0] hdr = {rd, len, a};
      cs_n = 0;
      tick(H);
      for (int i = 15; i >= 0; i--) begin
         sdi = hdr[i];
         tick(H);
         sclk = 1;
         if (i == 0 && rd) re_at[cyc + LAT] = 1;
         tick(H);
         sclk = 0;
         if (i == 0 && rd) begin
            oe_at[cyc + LAT] = 1;
            o_at[cyc + LAT]  = exp_mem[a][7];
         end
      end
      for (int b = 0; b < nbytes + ((tail > 0) ? 1 : 0); b++) begin
         int        nb  = (b < nbytes) ? 8 : tail;
         bit        act = in_count(len, b);
         bit [12:0] ab  = a + 13'(b);
         bit [7:0]  wb  = seed + 8'(b * 37);
         bit [7:0]  got = 0;
         for (int k = 0; k < nb; k++) begin
            int i = 7 - k;
            sdi = rd ? 1'b0 : wb[i];
            tick(H);
            sclk = 1;
            if (rd) begin
               got[i] = sdo;
               if (act) check(oe == 1'b1, "R1", "oe at host sample", int'(oe), 1);
            end
            if (i == 0) begin
               if (!rd && act) begin
                  we_at[cyc + LAT] = {ab, wb};
                  exp_mem[ab] = wb;
               end
               if (rd && in_count(len, b + 1)) re_at[cyc + LAT] = 1;
            end
            tick(H);
            sclk = 0;
            if (rd) begin
               int        j  = (i > 0) ? b : b + 1;
               int        p  = (i > 0) ? i - 1 : 7;
               bit [12:0] aj = a + 13'(j);
               oe_at[cyc + LAT] = in_count(len, j);
               if (in_count(len, j)) o_at[cyc + LAT] = exp_mem[aj][p];
            end
         end
         if (rd && act && nb == 8)
            check(got == exp_mem[ab], "R3/R4/R7", "read byte", int'(got), int'(exp_mem[ab]));
      end
      tick(H);
      cs_n = 1;
      oe_at[cyc + LAT] = 0;
      tick(3 * H);
   endtask

   task automatic check_mem(bit [12:0] a, string req);
      check(rf_mem[a] == exp_mem[a], req, "register content", int'(rf_mem[a]), int'(exp_mem[a]));
   endtask

   initial begin
      for (int a = 0; a < NREG; a++) begin
         rf_mem[a]  = 8'(a * 7 + 3);
         exp_mem[a] = 8'(a * 7 + 3);
      end
      rst_n = 0; cs_n = 1; sclk = 0; sdi = 0;
      tick(5);
      rst_n = 1;
      tick(2);
      check(oe == 1'b0 && we == 1'b0 && re == 1'b0, "R1", "reset outputs", int'({oe, we, re}), 0);

      // single write byte
      xfer(0, 2'b00, 13'h0010, 1, 0, 8'hA5);
      check_mem(13'h0010, "R3");
      // three-byte write wrapping past the top address
      xfer(0, 2'b10, 13'h1FFE, 3, 0, 8'h3C);
      check_mem(13'h1FFF, "R4"); check_mem(13'h0000, "R4");
      // two-byte code with four bytes sent: last two ignored
      xfer(0, 2'b01, 13'h0040, 4, 0, 8'h11);
      check_mem(13'h0041, "R5"); check_mem(13'h0042, "R5"); check_mem(13'h0043, "R5");
      // open-ended write of six bytes
      xfer(0, 2'b11, 13'h0100, 6, 0, 8'h90);
      for (int b = 0; b < 6; b++) check_mem(13'h0100 + 13'(b), "R6");
      // open-ended read back
      xfer(1, 2'b11, 13'h0100, 6, 0, 8'h00);
      // one-byte read code with two bytes clocked: pin released on the second
      xfer(1, 2'b00, 13'h0010, 2, 0, 8'h00);
      // write cut short in its second byte
      xfer(0, 2'b11, 13'h0200, 1, 5, 8'h77);
      check_mem(13'h0200, "R9"); check_mem(13'h0201, "R9");
      // two-byte read across the wrap
      xfer(1, 2'b01, 13'h1FFF, 2, 0, 8'h00);
      // read aborted mid-byte, then a fresh write
      xfer(1, 2'b11, 13'h0400, 1, 4, 8'h00);
      xfer(0, 2'b00, 13'h0401, 1, 0, 8'hE1);
      check_mem(13'h0401, "R2");
      // three-byte read code with four bytes clocked
      xfer(1, 2'b10, 13'h0040, 4, 0, 8'h00);

      begin
         int bad = 0;
         for (int a = 0; a < NREG; a++) if (rf_mem[a] != exp_mem[a]) bad++;
         check(bad == 0, "R4/R5/R9", "whole register file mismatches", bad, 0);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule